// File: doc/BRIEF.md
# Multi-Cycle RISC Integer Core

This block executes a small integer subset of a 32-bit fixed-width RISC instruction set, one instruction at a time. Each instruction word is fetched from a synchronous instruction port. The word is decoded from fixed bit positions, with the 6-bit opcode always in bits 31:26. The block then updates a 32-entry by 32-bit register file or performs one word access on a synchronous data port. Supported operations are register add and subtract, signed and unsigned immediate add, immediate OR, upper-immediate load, and word load and store.

There is no control flow. The program counter only ever advances by 4 after each instruction completes, and a one-cycle `retire` pulse marks every completion. A registered debug read port exposes any register so that a test environment can compare the architectural state against a model after each retirement.

Both memory ports have a fixed latency of one cycle. The address is driven from a register, and the memory returns data on the following cycle.

Top module: `tcore_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `imem_addr` is 0, `retire` is 0 and `dmem_we` is 0.
- R2: With opcode 0, `rd` (bits 15:11) receives `rs` (bits 25:21) plus `rt` (bits 20:16) when the function field (bits 5:0) is 32. It receives `rs` minus `rt`, modulo 2^32, when the function field is 34.
- R3: Opcode 8 writes `rs` plus the sign-extended 16-bit immediate (bits 15:0) into `rt`. Bit 15 of the immediate is copied into bits 31:16. The word 0x21840021 writes register 12 plus 33 into register 4.
- R4: Opcode 9 writes `rs` plus the zero-extended immediate into `rt`.
- R5: Opcode 13 writes `rs` OR the zero-extended immediate into `rt`.
- R6: Opcode 15 writes the immediate into bits 31:16 of `rt` and zeros into bits 15:0, whatever `rs` holds. Following it with an opcode-8 add of 0x4567 turns 0x1B23 into 0x1B234567.
- R7: Opcode 35 loads `rt` from the data word at `rs` plus the sign-extended offset. The word 0x8FAE0008 loads register 14 from register 29 plus 8. `dmem_re` is high for exactly one cycle.
- R8: Opcode 43 writes `rt` to the data word at `rs` plus the sign-extended offset, which may be negative. `dmem_we` is high for exactly one cycle and never together with `dmem_re`.
- R9: Register 0 always reads as 0, both as an operand and on the debug port. Writes to it are discarded.
- R10: Any other opcode, and any other function value under opcode 0, writes no register and no memory, but still retires.
- R11: `retire` is a one-cycle pulse. Retirements are 2 cycles apart for register and immediate operations and no-ops, 3 cycles for stores and 4 cycles for loads. In the retire cycle `imem_addr` equals the previous value plus 4.
- R12: `dbg_data` shows the register selected by `dbg_addr` one clock edge after the selection, and holds its old value until that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction to fetch (the program counter) |
| imem_rdata | input | 32 | Instruction word, valid one cycle after the address |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_re | output | 1 | Data read strobe |
| dmem_we | output | 1 | Data write strobe |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data, valid one cycle after the read strobe |
| dbg_addr | input | 5 | Register index for the debug read |
| dbg_data | output | 32 | Registered debug read value |
| retire | output | 1 | One-cycle pulse when an instruction completes |

## Verification
A register-writing instruction has updated the register file by the edge that raises `retire`. The bench therefore selects the target register on the falling edge of the retire cycle and compares `dbg_data` one falling edge later. That is before the next instruction can write at its execute edge, which comes at least two cycles after the previous retirement. Store results are read from the bench memory in the retire cycle itself, since the write lands on the same edge. The spacing between retirements is measured with a free-running cycle count and compared with the 2-, 3- and 4-cycle latencies. The program counter is sampled in the retire cycle. For the debug port, the value is checked once before the selecting edge and once after it.

// File: rtl/tcore_pkg.sv
package tcore_pkg;
  localparam int XLEN    = 32;
  localparam int REG_AW  = 5;
  localparam int OPC_W   = 6;
  localparam int IMM_W   = 16;
  localparam int PC_STEP = XLEN / 8;

  localparam logic [OPC_W-1:0] OPC_REG   = 6'd0;
  localparam logic [OPC_W-1:0] OPC_ADDS  = 6'd8;
  localparam logic [OPC_W-1:0] OPC_ADDU  = 6'd9;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'd13;
  localparam logic [OPC_W-1:0] OPC_UPPER = 6'd15;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'd35;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'd43;

  localparam logic [OPC_W-1:0] FN_ADD = 6'd32;
  localparam logic [OPC_W-1:0] FN_SUB = 6'd34;

  typedef enum logic [2:0] {
    K_NOP, K_ADD, K_SUB, K_OR, K_UPPER, K_LOAD, K_STORE
  } kind_e;

  typedef enum logic [1:0] {S_FETCH, S_EXEC, S_MEM, S_WB} state_e;

  typedef struct packed {
    kind_e             kind;
    logic [REG_AW-1:0] rs;
    logic [REG_AW-1:0] rt;
    logic [REG_AW-1:0] dst;
    logic              use_imm;
    logic [XLEN-1:0]   imm;
    logic              wr_en;
  } dec_t;
endpackage

// File: rtl/tcore_decode.sv
module tcore_decode
  import tcore_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output dec_t            dec
);
  logic [OPC_W-1:0] opc;
  logic [OPC_W-1:0] fn;
  logic [IMM_W-1:0] imm16;
  logic             unused_shamt;

  assign opc          = instr[31:26];
  assign fn           = instr[5:0];
  assign imm16        = instr[IMM_W-1:0];
  assign unused_shamt = ^instr[10:6];

  always_comb begin
    dec         = '0;
    dec.kind    = K_NOP;
    dec.rs      = instr[25:21];
    dec.rt      = instr[20:16];
    dec.dst     = instr[20:16];
    dec.use_imm = 1'b1;
    dec.imm     = {{(XLEN-IMM_W){imm16[IMM_W-1]}}, imm16};
    case (opc)
      OPC_REG: begin
        dec.use_imm = 1'b0;
        dec.dst     = instr[15:11];
        case (fn)
          FN_ADD:  dec.kind = K_ADD;
          FN_SUB:  dec.kind = K_SUB;
          default: dec.kind = K_NOP;
        endcase
      end
      OPC_ADDS: dec.kind = K_ADD;
      OPC_ADDU: begin
        dec.kind = K_ADD;
        dec.imm  = {{(XLEN-IMM_W){1'b0}}, imm16};
      end
      OPC_ORI: begin
        dec.kind = K_OR;
        dec.imm  = {{(XLEN-IMM_W){1'b0}}, imm16};
      end
      OPC_UPPER: begin
        dec.kind = K_UPPER;
        dec.imm  = {imm16, {(XLEN-IMM_W){1'b0}}};
      end
      OPC_LOAD:  dec.kind = K_LOAD;
      OPC_STORE: dec.kind = K_STORE;
      default:   dec.kind = K_NOP;
    endcase
    dec.wr_en = (dec.kind == K_ADD) || (dec.kind == K_SUB) ||
                (dec.kind == K_OR)  || (dec.kind == K_UPPER);
  end
endmodule

// File: rtl/tcore_alu.sv
module tcore_alu
  import tcore_pkg::*;
(
  input  kind_e           kind,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  always_comb begin
    case (kind)
      K_SUB:   y = a - b;
      K_OR:    y = a | b;
      K_UPPER: y = b;
      K_NOP:   y = '0;
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/tcore_regfile.sv
module tcore_regfile #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] dbg_a,
  output logic [W-1:0]  dbg_q
);
  localparam int N = 1 << AW;

  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we && (wa != '0)) mem[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : mem[ra1];
  assign rd2 = (ra2 == '0) ? '0 : mem[ra2];

  always_ff @(posedge clk) begin
    if (rst) dbg_q <= '0;
    else     dbg_q <= (dbg_a == '0) ? '0 : mem[dbg_a];
  end
endmodule

// File: rtl/tcore_top.sv
module tcore_top
  import tcore_pkg::*;
#(
  parameter logic [XLEN-1:0] PC_RESET = '0
) (
  input  logic              clk,
  input  logic              rst,
  output logic [XLEN-1:0]   imem_addr,
  input  logic [XLEN-1:0]   imem_rdata,
  output logic [XLEN-1:0]   dmem_addr,
  output logic              dmem_re,
  output logic              dmem_we,
  output logic [XLEN-1:0]   dmem_wdata,
  input  logic [XLEN-1:0]   dmem_rdata,
  input  logic [REG_AW-1:0] dbg_addr,
  output logic [XLEN-1:0]   dbg_data,
  output logic              retire
);
  localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

  state_e            state;
  logic [XLEN-1:0]   pc;
  dec_t              dec;
  logic [XLEN-1:0]   rs_val, rt_val, opb, alu_y;
  logic [REG_AW-1:0] ld_dst;
  logic              mem_is_store;
  logic              rf_we;
  logic [REG_AW-1:0] rf_wa;
  logic [XLEN-1:0]   rf_wd;

  tcore_decode u_dec (.instr(imem_rdata), .dec(dec));

  tcore_regfile #(.W(XLEN), .AW(REG_AW)) u_rf (
    .clk(clk), .rst(rst),
    .ra1(dec.rs), .ra2(dec.rt), .rd1(rs_val), .rd2(rt_val),
    .we(rf_we), .wa(rf_wa), .wd(rf_wd),
    .dbg_a(dbg_addr), .dbg_q(dbg_data)
  );

  assign opb = dec.use_imm ? dec.imm : rt_val;

  tcore_alu u_alu (.kind(dec.kind), .a(rs_val), .b(opb), .y(alu_y));

  always_comb begin
    rf_we = 1'b0;
    rf_wa = dec.dst;
    rf_wd = alu_y;
    if (state == S_EXEC && dec.wr_en) begin
      rf_we = 1'b1;
    end else if (state == S_WB) begin
      rf_we = 1'b1;
      rf_wa = ld_dst;
      rf_wd = dmem_rdata;
    end
  end

  assign imem_addr = pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_FETCH;
      pc           <= PC_RESET;
      retire       <= 1'b0;
      dmem_addr    <= '0;
      dmem_re      <= 1'b0;
      dmem_we      <= 1'b0;
      dmem_wdata   <= '0;
      ld_dst       <= '0;
      mem_is_store <= 1'b0;
    end else begin
      retire <= 1'b0;
      case (state)
        S_FETCH: state <= S_EXEC;
        S_EXEC: begin
          case (dec.kind)
            K_LOAD: begin
              dmem_addr    <= alu_y;
              dmem_re      <= 1'b1;
              ld_dst       <= dec.rt;
              mem_is_store <= 1'b0;
              state        <= S_MEM;
            end
            K_STORE: begin
              dmem_addr    <= alu_y;
              dmem_wdata   <= rt_val;
              dmem_we      <= 1'b1;
              mem_is_store <= 1'b1;
              state        <= S_MEM;
            end
            default: begin
              pc     <= pc + STEP;
              retire <= 1'b1;
              state  <= S_FETCH;
            end
          endcase
        end
        S_MEM: begin
          dmem_we <= 1'b0;
          dmem_re <= 1'b0;
          if (mem_is_store) begin
            pc     <= pc + STEP;
            retire <= 1'b1;
            state  <= S_FETCH;
          end else begin
            state <= S_WB;
          end
        end
        default: begin
          pc     <= pc + STEP;
          retire <= 1'b1;
          state  <= S_FETCH;
        end
      endcase
    end
  end
endmodule

// File: rtl/tcore_chk.sv
module tcore_chk
  import tcore_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [XLEN-1:0]   imem_addr,
  input logic              retire,
  input logic              dmem_we,
  input logic              dmem_re,
  input logic [REG_AW-1:0] dbg_addr,
  input logic [XLEN-1:0]   dbg_data
);
  AST_RETIRE_PULSE: assert property (@(posedge clk) disable iff (rst) retire |=> !retire); // R11
  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst) retire |-> (imem_addr == $past(imem_addr) + XLEN'(PC_STEP))); // R11
  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (rst) dmem_re |=> !dmem_re); // R7
  AST_STORE_PULSE: assert property (@(posedge clk) disable iff (rst) dmem_we |=> !dmem_we); // R8
  AST_MEM_EXCL: assert property (@(posedge clk) disable iff (rst) !(dmem_we && dmem_re)); // R8
  AST_ZERO_REG: assert property (@(posedge clk) disable iff (rst) ($past(dbg_addr) == '0) |-> (dbg_data == '0)); // R9
endmodule

bind tcore_top tcore_chk u_chk (
  .clk(clk), .rst(rst), .imem_addr(imem_addr), .retire(retire),
  .dmem_we(dmem_we), .dmem_re(dmem_re), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
);

// File: tb/tcore_top_tb_top.sv
`timescale 1ns/1ps
module tcore_top_tb_top;
  localparam int NPROG = 17;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata, dbg_data;
  logic        dmem_re, dmem_we, retire;
  logic [4:0]  dbg_addr = 5'd0;

  always #2 clk = ~clk;

  tcore_top dut_i (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_re(dmem_re), .dmem_we(dmem_we),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data), .retire(retire)
  );

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  string       ptag [64];

  always @(posedge clk) imem_rdata <= imem[imem_addr[7:2]];
  always @(posedge clk) begin
    if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
    dmem_rdata <= dmem[dmem_addr[7:2]];
  end

  int cyc = 0;
  int stores_seen = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst && dmem_we) stores_seen <= stores_seen + 1;
  end

  int n_chk = 0;
  int n_fail = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ienc(input int op, input int rs, input int rt, input logic [15:0] imm);
    return {op[5:0], rs[4:0], rt[4:0], imm};
  endfunction
  function automatic logic [31:0] renc(input int rs, input int rt, input int rd, input int fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction

  // scoreboard: kind 0 = register, 1 = memory word
  int          q_kind[$];
  int          q_idx[$];
  int          q_lat[$];
  logic [31:0] q_val[$];
  string       q_tag[$];

  logic [31:0] mreg [32];
  logic [31:0] mmem [64];

  task automatic drive_program();
    for (int n = 0; n < NPROG; n++) begin
      logic [31:0] w, sx, zx, res;
      int op, rs, rt, rd, fn, dst, lat, kind, idx;
      bit wr;
      w  = imem[n];
      op = int'(w[31:26]); rs = int'(w[25:21]); rt = int'(w[20:16]);
      rd = int'(w[15:11]); fn = int'(w[5:0]);
      sx = {{16{w[15]}}, w[15:0]};
      zx = {16'd0, w[15:0]};
      wr = 1'b1; lat = 2; kind = 0; dst = rt; res = 32'd0;
      if (op == 0) begin
        dst = rd;
        if (fn == 32)      res = mreg[rs] + mreg[rt];
        else if (fn == 34) res = mreg[rs] - mreg[rt];
        else               wr = 1'b0;
      end else if (op == 8)  res = mreg[rs] + sx;
      else if (op == 9)  res = mreg[rs] + zx;
      else if (op == 13) res = mreg[rs] | zx;
      else if (op == 15) res = {w[15:0], 16'd0};
      else if (op == 35) begin res = mmem[((mreg[rs] + sx) >> 2) & 63]; lat = 4; end
      else if (op == 43) begin
        wr = 1'b0; lat = 3; kind = 1;
        idx = int'(((mreg[rs] + sx) >> 2) & 63);
        mmem[idx] = mreg[rt];
      end else wr = 1'b0;
      if (wr && dst != 0) mreg[dst] = res;
      if (kind == 1) begin
        q_kind.push_back(1); q_idx.push_back(idx); q_val.push_back(mmem[idx]);
      end else begin
        q_kind.push_back(0); q_idx.push_back(dst); q_val.push_back(mreg[dst]);
      end
      q_lat.push_back(lat);
      q_tag.push_back(ptag[n]);
    end
  endtask

  int n_ret = 0;
  initial begin
    int last;
    last = 0;
    forever begin
      @(negedge clk);
      if (!rst && retire && q_kind.size() > 0) begin
        int k, ix, lt;
        logic [31:0] v;
        string tg;
        k = q_kind.pop_front(); ix = q_idx.pop_front(); v = q_val.pop_front();
        lt = q_lat.pop_front(); tg = q_tag.pop_front();
        chk(imem_addr == 32'(4 * (n_ret + 1)), "R11 pc step", imem_addr, 32'(4 * (n_ret + 1)));
        if (n_ret > 0) chk(cyc - last == lt, "R11 retire spacing", 32'(cyc - last), 32'(lt));
        last = cyc;
        if (k == 1) begin
          chk(dmem[ix] === v, tg, dmem[ix], v);
        end else begin
          dbg_addr = ix[4:0];
          @(negedge clk);
          chk(dbg_data === v, tg, dbg_data, v);
        end
        n_ret++;
      end
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'd0; ptag[i] = "none";
      dmem[i] = 32'hC0DE0000 | 32'(i);
      mmem[i] = 32'hC0DE0000 | 32'(i);
    end
    for (int i = 0; i < 32; i++) mreg[i] = 32'd0;
    imem[0]  = ienc(13, 0, 12, 16'd100);      ptag[0]  = "R5 ori";
    imem[1]  = 32'h21840021;                  ptag[1]  = "R3 addi 0x21840021";
    imem[2]  = ienc(8, 0, 5, 16'hFFFE);       ptag[2]  = "R3 sign extend";
    imem[3]  = ienc(9, 0, 6, 16'hFFFE);       ptag[3]  = "R4 zero extend";
    imem[4]  = ienc(13, 0, 7, 16'h8001);      ptag[4]  = "R5 or zero extend";
    imem[5]  = ienc(15, 7, 8, 16'h1B23);      ptag[5]  = "R6 upper";
    imem[6]  = ienc(8, 8, 8, 16'h4567);       ptag[6]  = "R6 upper+add";
    imem[7]  = renc(4, 5, 9, 32);             ptag[7]  = "R2 add";
    imem[8]  = renc(4, 6, 10, 34);            ptag[8]  = "R2 sub";
    imem[9]  = ienc(13, 0, 29, 16'd16);       ptag[9]  = "R5 base";
    imem[10] = 32'h8FAE0008;                  ptag[10] = "R7 load 0x8FAE0008";
    imem[11] = ienc(43, 29, 8, 16'hFFFC);     ptag[11] = "R8 store neg offset";
    imem[12] = ienc(35, 0, 15, 16'd12);       ptag[12] = "R7 load back";
    imem[13] = ienc(8, 4, 0, 16'd5);          ptag[13] = "R9 write r0";
    imem[14] = renc(0, 4, 16, 32);            ptag[14] = "R9 read r0";
    imem[15] = ienc(63, 4, 4, 16'd1);         ptag[15] = "R10 bad opcode";
    imem[16] = renc(4, 4, 9, 42);             ptag[16] = "R10 bad function";
    drive_program();

    repeat (3) @(negedge clk);
    chk(imem_addr == 32'd0, "R1 reset pc", imem_addr, 32'd0);
    chk(retire == 1'b0, "R1 reset retire", {31'd0, retire}, 32'd0);
    chk(dmem_we == 1'b0, "R1 reset we", {31'd0, dmem_we}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(imem_addr == 32'd0 && !retire, "R1 after reset", imem_addr, 32'd0);

    for (int k = 0; k < 3000 && n_ret < NPROG; k++) @(negedge clk);
    if (n_ret < NPROG) chk(1'b0, "watchdog", 32'(n_ret), 32'(NPROG));

    @(negedge clk);
    chk(stores_seen == 1, "R10 no extra stores", 32'(stores_seen), 32'd1);
    dbg_addr = 5'd8;
    @(negedge clk);
    dbg_addr = 5'd4;
    #1;
    chk(dbg_data === mreg[8], "R12 hold before edge", dbg_data, mreg[8]);
    @(negedge clk);
    chk(dbg_data === mreg[4], "R12 after edge", dbg_data, mreg[4]);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule